// File: doc/BRIEF.md
# Three-Wire Serial Register Writer

This block is a master that programs a synthesizer-style device over three wires: a serial clock, a serial data line and a latch enable. A client hands it one 32-bit word at a time over a valid/ready request port. The block shifts the word out most significant bit first. Data changes only while the serial clock is low. After the last clock pulse and a short gap, it raises latch enable for a timed pulse so the device commits the word.

The device picks its target register from the three least significant bits of the word. Those bits are therefore the last ones shifted out. Every timing minimum is given in nanoseconds as a parameter. The block converts each minimum to whole system-clock cycles using a clock-period parameter, rounding up, with a floor of one cycle.

A busy flag reports a transfer in progress. A one-cycle done pulse marks the end of each write. A synchronous active-low reset aborts any partly shifted word and returns all three serial lines low.

Top module: `tw_reg_writer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block enters idle: `sclk`, `sdata`, `le` and `done` are 0, `req_ready` is 1 and `busy` is 0, and any partly shifted word is abandoned.
- R2: A word is accepted at a rising edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` is 0 and `busy` is 1, and they stay so until the latch-enable pulse has ended. `busy` is always the complement of `req_ready`.
- R3: A `req_valid` pulse while `req_ready` is 0 has no effect on any output.
- R4: The 32 data bits leave on `sdata` in the order bit 31 down to bit 0, one bit per serial clock pulse, so the 3-bit register address in bits 2..0 is shifted last. `sdata` is 0 in idle.
- R5: `sdata` holds its value during every cycle in which `sclk` is 1. It changes only on entry to a low phase of `sclk`.
- R6: Each `sclk` high phase lasts N_HIGH cycles. Each low phase between two pulses lasts N_LOW cycles.
- R7: In the N_LEAD cycles after acceptance, `sclk` and `le` are 0 and `sdata` already carries bit 31. N_LEAD is the larger of the latch-setup and clock-low minimums in cycles.
- R8: After the final `sclk` high phase, `sclk` and `le` stay 0 for N_GAP cycles before `le` rises. `le` and `sclk` are never 1 together.
- R9: `le` is 1 for exactly N_PULSE cycles. `done` is 1 for the single cycle after that, in which `req_ready` is already 1. A new word may be accepted in that same cycle.
- R10: Each cycle count is ceil(minimum_ns / CLK_PERIOD_NS), and at least 1. With the defaults this gives N_LEAD=3, N_HIGH=3, N_LOW=3, N_GAP=1 and N_PULSE=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request word is valid |
| req_word | input | 32 | Word to program, register address in bits 2..0 |
| req_ready | output | 1 | Block is idle and accepts a word |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock to the device |
| sdata | output | 1 | Serial data to the device |
| le | output | 1 | Latch enable to the device |
| done | output | 1 | One-cycle pulse after each completed write |

## Verification
All outputs come from flops, so each result is due a fixed number of cycles after the acceptance edge:
- the lead values appear in the first cycle after acceptance;
- the first `sclk` rise comes N_LEAD cycles later;
- each following pulse is N_HIGH+N_LOW cycles after the one before;
- `le` rises N_GAP cycles after the last high phase;
- `done` follows N_PULSE cycles after that.

The bench builds the full expected waveform of every write as a per-cycle queue of behavioural values, starting at the acceptance edge. It compares every output at each falling clock edge, which is half a cycle after the register update. The queue is discarded when reset is applied, and an ignored request leaves it untouched.

// File: rtl/tw_pkg.sv
// Package: shared state type and the nanosecond-to-cycle conversion used to
// derive every phase length of the serial writer.
// Assumes: timing minimums and clock period are positive integers in ns.
package tw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_GAP,
        ST_PULSE
    } tw_state_t;

    // Round a nanosecond minimum up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tw_phase_timer.sv
// Module: down-counter that times the current phase.
// Loading N-1 on phase entry makes 'expired' true in the phase's last cycle.
// Assumes: load_val fits in CNT_W bits.
module tw_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Load on phase entry, else count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/tw_shifter.sv
// Module: word shift register with a remaining-bit counter.
// Its MSB flop drives the serial data line directly, so the line never glitches.
// Assumes: shift is requested only while bits remain; clear returns it to zero.
module tw_shifter #(
    parameter int WORD_W = 32,
    parameter int BIT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              clear,
    input  logic [WORD_W-1:0] word,
    output logic              msb,
    output logic              last
);

    logic [WORD_W-1:0] sh;
    logic [BIT_W-1:0]  rem;

    // Capture a word, advance by one bit, or clear back to the idle value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh  <= '0;
            rem <= '0;
        end else if (load) begin
            sh  <= word;
            rem <= BIT_W'(WORD_W - 1);
        end else if (shift) begin
            sh  <= {sh[WORD_W-2:0], 1'b0};
            rem <= rem - 1'b1;
        end
    end

    assign msb  = sh[WORD_W-1];
    assign last = (rem == '0);

endmodule

// File: rtl/tw_ctrl.sv
// Module: phase sequencer for one write.
// Phase order: lead, then alternating high/low clock phases, gap, latch pulse.
// Outputs are registered from the next state, so they change only at clock edges.
// Assumes: the timer and shifter respond to load, shift and clear in the same edge.
module tw_ctrl
    import tw_pkg::*;
#(
    parameter int CNT_W   = 2,
    parameter int N_LEAD  = 3,
    parameter int N_HIGH  = 3,
    parameter int N_LOW   = 3,
    parameter int N_GAP   = 1,
    parameter int N_PULSE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             t_exp,
    input  logic             last_bit,
    output logic             t_load,
    output logic [CNT_W-1:0] t_val,
    output logic             sh_load,
    output logic             sh_shift,
    output logic             sh_clear,
    output logic             sclk,
    output logic             le,
    output logic             ready,
    output logic             done
);

    tw_state_t st, nxt;

    // Next-state and datapath-control decode for the current phase.
    always_comb begin
        nxt      = st;
        t_load   = 1'b0;
        t_val    = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_clear = 1'b0;
        case (st)
            ST_IDLE: if (req_valid) begin
                nxt     = ST_LEAD;
                t_load  = 1'b1;
                t_val   = CNT_W'(N_LEAD - 1);
                sh_load = 1'b1;
            end
            ST_LEAD: if (t_exp) begin
                nxt    = ST_HIGH;
                t_load = 1'b1;
                t_val  = CNT_W'(N_HIGH - 1);
            end
            ST_HIGH: if (t_exp) begin
                t_load = 1'b1;
                if (last_bit) begin
                    nxt   = ST_GAP;
                    t_val = CNT_W'(N_GAP - 1);
                end else begin
                    nxt      = ST_LOW;
                    t_val    = CNT_W'(N_LOW - 1);
                    sh_shift = 1'b1;
                end
            end
            ST_LOW: if (t_exp) begin
                nxt    = ST_HIGH;
                t_load = 1'b1;
                t_val  = CNT_W'(N_HIGH - 1);
            end
            ST_GAP: if (t_exp) begin
                nxt    = ST_PULSE;
                t_load = 1'b1;
                t_val  = CNT_W'(N_PULSE - 1);
            end
            ST_PULSE: if (t_exp) begin
                nxt      = ST_IDLE;
                sh_clear = 1'b1;
            end
            default: begin
                nxt      = ST_IDLE;
                sh_clear = 1'b1;
            end
        endcase
    end

    // State and registered output lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            sclk  <= 1'b0;
            le    <= 1'b0;
            ready <= 1'b1;
            done  <= 1'b0;
        end else begin
            st    <= nxt;
            sclk  <= (nxt == ST_HIGH);
            le    <= (nxt == ST_PULSE);
            ready <= (nxt == ST_IDLE);
            done  <= (st == ST_PULSE) && (nxt == ST_IDLE);
        end
    end

endmodule

// File: rtl/tw_reg_writer.sv
// Module: top of the three-wire serial register writer.
// Derives the phase lengths from the ns minimums and ties the sequencer,
// the phase timer and the shifter together.
// Assumes: one word in flight at a time; rst_n is synchronous to clk.
module tw_reg_writer
    import tw_pkg::*;
#(
    parameter int WORD_W        = 32,
    parameter int CLK_PERIOD_NS = 10,
    parameter int LE_SETUP_NS   = 20,
    parameter int SCLK_HIGH_NS  = 25,
    parameter int SCLK_LOW_NS   = 25,
    parameter int LE_DELAY_NS   = 10,
    parameter int LE_WIDTH_NS   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_word,
    output logic              req_ready,
    output logic              busy,
    output logic              sclk,
    output logic              sdata,
    output logic              le,
    output logic              done
);

    localparam int N_HIGH  = ns_to_cyc(SCLK_HIGH_NS, CLK_PERIOD_NS);
    localparam int N_LOW   = ns_to_cyc(SCLK_LOW_NS, CLK_PERIOD_NS);
    localparam int N_LEAD  = max2(ns_to_cyc(LE_SETUP_NS, CLK_PERIOD_NS), N_LOW);
    localparam int N_GAP   = ns_to_cyc(LE_DELAY_NS, CLK_PERIOD_NS);
    localparam int N_PULSE = ns_to_cyc(LE_WIDTH_NS, CLK_PERIOD_NS);
    localparam int N_MAX   = max2(max2(max2(N_HIGH, N_LOW), max2(N_LEAD, N_GAP)), N_PULSE);
    localparam int CNT_W   = (N_MAX > 1) ? $clog2(N_MAX) : 1;
    localparam int BIT_W   = $clog2(WORD_W);

    logic             t_load, t_exp;
    logic [CNT_W-1:0] t_val;
    logic             sh_load, sh_shift, sh_clear, last_bit;

    tw_ctrl #(
        .CNT_W(CNT_W), .N_LEAD(N_LEAD), .N_HIGH(N_HIGH),
        .N_LOW(N_LOW), .N_GAP(N_GAP), .N_PULSE(N_PULSE)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .t_exp(t_exp), .last_bit(last_bit),
        .t_load(t_load), .t_val(t_val),
        .sh_load(sh_load), .sh_shift(sh_shift), .sh_clear(sh_clear),
        .sclk(sclk), .le(le), .ready(req_ready), .done(done)
    );

    tw_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load),
        .load_val(t_val), .expired(t_exp)
    );

    tw_shifter #(.WORD_W(WORD_W), .BIT_W(BIT_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .shift(sh_shift),
        .clear(sh_clear), .word(req_word), .msb(sdata), .last(last_bit)
    );

    assign busy = ~req_ready;

endmodule

// File: rtl/tw_reg_writer_chk.sv
// Module: protocol checker bound to the writer's ports.
// Assumes: all checks are suspended while rst_n is low.
module tw_reg_writer_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic sclk,
    input logic sdata,
    input logic le,
    input logic done
);

    // R5
    sdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdata));

    // R2
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> $past(req_valid));

    // R9
    done_after_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(le) && !le && req_ready));

    // R8
    le_sclk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le |-> !sclk);

    // R8
    le_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(le) |-> !$past(sclk));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!sclk && !le));

endmodule

bind tw_reg_writer tw_reg_writer_chk i_chk (.*);

// File: tb/test_tw_reg_writer.sv
module test_tw_reg_writer;

    localparam int PER = 10;
    localparam int NH  = (25 + PER - 1) / PER;
    localparam int NLO = (25 + PER - 1) / PER;
    localparam int NL  = ((20 + PER - 1) / PER > NLO) ? (20 + PER - 1) / PER : NLO;
    localparam int NG  = (10 + PER - 1) / PER;
    localparam int NP  = (20 + PER - 1) / PER;

    typedef struct {
        bit    sclk;
        bit    sdata;
        bit    le;
        bit    ready;
        bit    done;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_word;
    logic        req_ready, busy, sclk, sdata, le, done;

    exp_t  q[$];
    string tag_ovr = "";
    int    n_chk   = 0;
    int    n_fail  = 0;

    always #5 clk = ~clk;

    tw_reg_writer i_tw_reg_writer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
        .req_ready(req_ready), .busy(busy), .sclk(sclk), .sdata(sdata),
        .le(le), .done(done)
    );

    task automatic chk(input string name, input bit act, input bit exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, name, act, exp, $time);
        end
    endtask

    // Build the per-cycle expected waveform of one write, from acceptance on.
    task automatic push_word(input logic [31:0] w);
        for (int c = 0; c < NL; c++) q.push_back('{0, w[31], 0, 0, 0, "R7 R10"});
        for (int b = 31; b >= 0; b--) begin
            if (b != 31)
                for (int c = 0; c < NLO; c++) q.push_back('{0, w[b], 0, 0, 0, "R6 R10"});
            for (int c = 0; c < NH; c++) q.push_back('{1, w[b], 0, 0, 0, "R5 R6"});
        end
        for (int c = 0; c < NG; c++) q.push_back('{0, w[0], 0, 0, 0, "R8"});
        for (int c = 0; c < NP; c++) q.push_back('{1'b0, w[0], 1'b1, 1'b0, 1'b0, "R9"});
        q.push_back('{0, 0, 0, 1, 1, "R9"});
    endtask

    // Advance to the next falling edge and compare all outputs with the model.
    task automatic tick();
        exp_t  e;
        string t;
        @(negedge clk);
        if (q.size() > 0) e = q.pop_front();
        else              e = '{0, 0, 0, 1, 0, "R1 R2"};
        t = (tag_ovr != "") ? tag_ovr : e.tag;
        chk("sclk",  sclk,      e.sclk,   t);
        chk("sdata", sdata,     e.sdata,  e.sclk ? "R5" : "R4");
        chk("le",    le,        e.le,     t);
        chk("ready", req_ready, e.ready,  (tag_ovr != "") ? tag_ovr : "R2");
        chk("busy",  busy,      !e.ready, (tag_ovr != "") ? tag_ovr : "R2");
        chk("done",  done,      e.done,   (tag_ovr != "") ? tag_ovr : "R9");
    endtask

    task automatic start(input logic [31:0] w);
        while (q.size() != 0) tick();
        req_valid = 1'b1;
        req_word  = w;
        push_word(w);
        tick();
        req_valid = 1'b0;
        req_word  = '0;
    endtask

    task automatic drain();
        while (q.size() != 0) tick();
    endtask

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_word  = '0;
        @(negedge clk);
        tag_ovr = "R1";
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        tag_ovr = "";

        // Single write with address bits 111 shifted last.
        start(32'hA5C3_0F17);
        drain();
        tick();

        // Back-to-back writes, each issued in the previous done cycle.
        start(32'hFFFF_FFFF);
        start(32'h0000_0000);
        start(32'h8000_0001);
        drain();

        // Request while busy must be ignored (R3).
        start(32'h1234_5678);
        for (int i = 0; i < 20; i++) tick();
        req_valid = 1'b1;
        req_word  = 32'hDEAD_BEEF;
        tag_ovr   = "R3";
        tick();
        req_valid = 1'b0;
        req_word  = '0;
        tick();
        tag_ovr = "";
        drain();
        tick();

        // Reset in mid-word drops the transfer (R1).
        start(32'hC0DE_0005);
        for (int i = 0; i < 40; i++) tick();
        rst_n = 1'b0;
        q.delete();
        tag_ovr = "R1";
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        tag_ovr = "";

        // Write after the aborted one completes normally.
        start(32'h5A5A_A5A2);
        drain();
        tick();
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(1_000_000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule